// File: doc/BRIEF.md
# Destructive-Read Core Memory Cycle Controller

This block runs one access of a word-organised magnetic memory whose read wipes the stored word. Every access, read or store, has the same two phases. In the select phase, the latched address picks one X line and one Y line, and a sense strobe is raised. Each data bit answers on one of two polarity inputs. In the drive phase, each bit raises exactly one of its two bit-selection lines, chosen by the data register.

For a read, the register takes the sensed word, so the drive phase puts the old contents back. For a store, the register is loaded with the new word at the start strobe. The select phase then only clears the word, and the drive phase writes the new value. A bit that never answers inside a programmable window sets an error flag. The drive phase still runs from whatever the register holds.

Top module: `wordmem_cycle_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `strobe` and `err` are 0, every `x_sel` line is 0, every `y_sel` line is 1, and both bit-line buses and `rdata` are 0.
- R2: A `start` seen while idle latches `addr`, `store` and `wdata`, and `busy` rises at the next edge. A `start` seen while busy has no effect: it changes neither the selected lines nor the number of cycles, and it does not begin a new access.
- R3: During the select phase `strobe` is 1 and `x_sel` has a single 1 at index `addr[ADDR_W-1:Y_BITS]`. `y_sel` is all ones except a 0 at index `addr[Y_BITS-1:0]`. Outside the select phase `x_sel` is all zeros and `y_sel` is all ones.
- R4: A bit responds in a strobe cycle when exactly one of `sense_one`/`sense_zero` is 1. Only a bit's first response counts. On a read, `sense_one` stores 1 and `sense_zero` stores 0. Sense inputs are ignored outside the strobe.
- R5: The select phase ends at the clock edge where the last bit responds. A word whose bits all respond in the first strobe cycle has a one-cycle select phase.
- R6: With L = `timeout_lim` (0 treated as 1), the select phase may last at most L cycles. If some bit has still not responded at the edge ending cycle L, `err` is set. On a read, the missing bits hold 0, and the drive phase still runs.
- R7: The drive phase lasts RESTORE_CYCLES cycles. In it, each bit raises `drv_one` when its register bit is 1 and `drv_zero` when it is 0, never both. Outside the drive phase both buses are 0.
- R8: On a read, the drive phase uses the sensed word, so the word is put back, and `rdata` holds that word after the access.
- R9: On a store, the drive phase uses `wdata` as sampled at the accepted `start`. Sense polarities do not change it.
- R10: `done` is a one-cycle pulse at the edge ending the drive phase, in the same cycle that `busy` falls. `err` stays set until the next accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Access request |
| addr | input | X_BITS+Y_BITS | Word address, X field in the upper bits |
| store | input | 1 | 1 = store access, 0 = read access |
| wdata | input | WORD_W | Word to store |
| timeout_lim | input | TMO_W | Select-phase length limit in clocks |
| sense_one | input | WORD_W | Per-bit response of polarity one |
| sense_zero | input | WORD_W | Per-bit response of polarity zero |
| strobe | output | 1 | Sense window, high during the select phase |
| x_sel | output | 2**X_BITS | X select lines, active high |
| y_sel | output | 2**Y_BITS | Y select lines, idle high, addressed line low |
| drv_one | output | WORD_W | Bit line that writes a 1 |
| drv_zero | output | WORD_W | Bit line that writes a 0 |
| rdata | output | WORD_W | Data register |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| err | output | 1 | Missing-response flag |

## Verification
The bench builds the block with 2-bit X and Y fields, a 6-bit word, a 4-bit timeout limit and a 3-cycle drive phase. This makes all 16 addresses small enough to sweep, both as stores and as reads. A model array in the bench answers the strobe and absorbs the bit lines. Late bits are placed at every bit position and at several delays. The timeout window is hit exactly at its last cycle, one cycle past it, and with a zero limit. Start requests are pushed into both phases to check that they are ignored.

// File: rtl/wmc_pkg.sv
package wmc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SENSE = 2'd1,
      PH_DRIVE = 2'd2
   } phase_t;
endpackage

// File: rtl/wmc_line_decode.sv
module wmc_line_decode #(
   parameter int  SEL_BITS    = 6,
   parameter bit  IDLE_ACTIVE = 1'b0
) (
   input  logic                       en,
   input  logic [SEL_BITS-1:0]        idx,
   output logic [(1<<SEL_BITS)-1:0]   lines
);
   localparam int LINES = 1 << SEL_BITS;

   if (SEL_BITS < 1) begin : g_bad_width
      $error("wmc_line_decode: SEL_BITS must be at least 1");
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic hit;
      assign hit = en && (idx == SEL_BITS'(i));
      if (IDLE_ACTIVE) begin : g_idle_high
         assign lines[i] = ~hit;
      end else begin : g_idle_low
         assign lines[i] = hit;
      end
   end
endmodule

// File: rtl/wmc_bit_lane.sv
module wmc_bit_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic load_en,
   input  logic load_val,
   input  logic sample_en,
   input  logic is_read,
   input  logic pos,
   input  logic neg,
   input  logic drive_en,
   output logic seen_nx,
   output logic val,
   output logic b_one,
   output logic b_zero
);
   logic seen;
   logic rsp;

   assign rsp     = sample_en && (pos ^ neg);
   assign seen_nx = seen || rsp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen <= 1'b0;
         val  <= 1'b0;
      end else if (accept) begin
         seen <= 1'b0;
         val  <= load_en ? load_val : 1'b0;
      end else if (rsp && !seen) begin
         seen <= 1'b1;
         if (is_read) val <= pos;
      end
   end

   assign b_one  = drive_en && val;
   assign b_zero = drive_en && !val;

   // R4: a captured bit ignores later responses
   p_first_rsp_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && sample_en) |=> $stable(val));
   // R4: a response, once seen, stays recorded until the next access
   p_seen_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !accept) |=> seen);
   // R9: a store keeps its word through the sense window
   p_store_word_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && !is_read) |=> $stable(val));
endmodule

// File: rtl/wmc_sequencer.sv
module wmc_sequencer
   import wmc_pkg::*;
#(
   parameter int TMO_W          = 8,
   parameter int RESTORE_CYCLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             all_seen,
   input  logic [TMO_W-1:0] timeout_lim,
   output logic             accept,
   output logic             sense_en,
   output logic             drive_en,
   output logic             busy,
   output logic             done,
   output logic             err
);
   localparam int RC_W = (RESTORE_CYCLES > 1) ? $clog2(RESTORE_CYCLES) : 1;
   localparam logic [RC_W-1:0] RC_LAST = RC_W'(RESTORE_CYCLES - 1);

   if (RESTORE_CYCLES < 1) begin : g_bad_restore
      $error("wmc_sequencer: RESTORE_CYCLES must be at least 1");
   end
   if (TMO_W < 1) begin : g_bad_tmo
      $error("wmc_sequencer: TMO_W must be at least 1");
   end

   phase_t           ph;
   logic [TMO_W-1:0] wait_cnt;
   logic [RC_W-1:0]  drv_cnt;
   logic             window_last;
   logic             drv_last;

   assign window_last = ((TMO_W+1)'(wait_cnt) + (TMO_W+1)'(1)) >= (TMO_W+1)'(timeout_lim);
   assign drv_last    = (drv_cnt == RC_LAST);

   assign accept   = (ph == PH_IDLE) && start;
   assign sense_en = (ph == PH_SENSE);
   assign drive_en = (ph == PH_DRIVE);
   assign busy     = (ph != PH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         wait_cnt <= '0;
         drv_cnt  <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (ph)
            PH_IDLE: begin
               if (start) begin
                  ph       <= PH_SENSE;
                  wait_cnt <= '0;
                  err      <= 1'b0;
               end
            end
            PH_SENSE: begin
               if (all_seen) begin
                  ph      <= PH_DRIVE;
                  drv_cnt <= '0;
               end else if (window_last) begin
                  ph      <= PH_DRIVE;
                  drv_cnt <= '0;
                  err     <= 1'b1;
               end else begin
                  wait_cnt <= wait_cnt + 1'b1;
               end
            end
            PH_DRIVE: begin
               if (drv_last) begin
                  ph   <= PH_IDLE;
                  done <= 1'b1;
               end else begin
                  drv_cnt <= drv_cnt + 1'b1;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_with_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_err_from_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past(ph == PH_SENSE));
   p_no_restart_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_en && drv_last && start) |=> !busy);
endmodule

// File: rtl/wordmem_cycle_ctrl.sv
module wordmem_cycle_ctrl #(
   parameter int X_BITS         = 6,
   parameter int Y_BITS         = 6,
   parameter int WORD_W         = 50,
   parameter int TMO_W          = 8,
   parameter int RESTORE_CYCLES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [X_BITS+Y_BITS-1:0]     addr,
   input  logic                         store,
   input  logic [WORD_W-1:0]            wdata,
   input  logic [TMO_W-1:0]             timeout_lim,
   input  logic [WORD_W-1:0]            sense_one,
   input  logic [WORD_W-1:0]            sense_zero,
   output logic                         strobe,
   output logic [(1<<X_BITS)-1:0]       x_sel,
   output logic [(1<<Y_BITS)-1:0]       y_sel,
   output logic [WORD_W-1:0]            drv_one,
   output logic [WORD_W-1:0]            drv_zero,
   output logic [WORD_W-1:0]            rdata,
   output logic                         busy,
   output logic                         done,
   output logic                         err
);
   localparam int ADDR_W = X_BITS + Y_BITS;

   if (WORD_W < 1) begin : g_bad_word
      $error("wordmem_cycle_ctrl: WORD_W must be at least 1");
   end

   logic              accept;
   logic              sense_en;
   logic              drive_en;
   logic              all_seen;
   logic [ADDR_W-1:0] addr_q;
   logic              store_q;
   logic [WORD_W-1:0] seen_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         store_q <= 1'b0;
      end else if (accept) begin
         addr_q  <= addr;
         store_q <= store;
      end
   end

   wmc_sequencer #(
      .TMO_W          (TMO_W),
      .RESTORE_CYCLES (RESTORE_CYCLES)
   ) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .all_seen    (all_seen),
      .timeout_lim (timeout_lim),
      .accept      (accept),
      .sense_en    (sense_en),
      .drive_en    (drive_en),
      .busy        (busy),
      .done        (done),
      .err         (err)
   );

   assign strobe = sense_en;

   wmc_line_decode #(.SEL_BITS(X_BITS), .IDLE_ACTIVE(1'b0)) i_xdec (
      .en    (sense_en),
      .idx   (addr_q[ADDR_W-1:Y_BITS]),
      .lines (x_sel)
   );

   wmc_line_decode #(.SEL_BITS(Y_BITS), .IDLE_ACTIVE(1'b1)) i_ydec (
      .en    (sense_en),
      .idx   (addr_q[Y_BITS-1:0]),
      .lines (y_sel)
   );

   for (genvar b = 0; b < WORD_W; b++) begin : g_lane
      wmc_bit_lane i_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .accept    (accept),
         .load_en   (store),
         .load_val  (wdata[b]),
         .sample_en (sense_en),
         .is_read   (!store_q),
         .pos       (sense_one[b]),
         .neg       (sense_zero[b]),
         .drive_en  (drive_en),
         .seen_nx   (seen_nx[b]),
         .val       (rdata[b]),
         .b_one     (drv_one[b]),
         .b_zero    (drv_zero[b])
      );
   end

   assign all_seen = &seen_nx;

   p_x_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(x_sel));
   p_y_single_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~y_sel) <= 1);
   p_select_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (x_sel != '0) |-> strobe);
   p_busy_start_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && start) |=> (!strobe || ($stable(x_sel) && $stable(y_sel))));
   p_lines_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (drv_one == '0 && drv_zero == '0));
   p_lines_disjoint_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_one & drv_zero) == '0);
endmodule

// File: tb/test_wordmem_cycle_ctrl.sv
`timescale 1ns/1ps
module test_wordmem_cycle_ctrl;
   localparam int XB = 2;
   localparam int YB = 2;
   localparam int W  = 6;
   localparam int TW = 4;
   localparam int RC = 3;
   localparam int AW = XB + YB;
   localparam int NW = 1 << AW;
   localparam logic [W-1:0] MASK = '1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [AW-1:0]     addr = '0;
   logic              store = 1'b0;
   logic [W-1:0]      wdata = '0;
   logic [TW-1:0]     timeout_lim = '0;
   logic [W-1:0]      sense_one = '0;
   logic [W-1:0]      sense_zero = '0;
   logic              strobe;
   logic [(1<<XB)-1:0] x_sel;
   logic [(1<<YB)-1:0] y_sel;
   logic [W-1:0]      drv_one, drv_zero, rdata;
   logic              busy, done, err;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [W-1:0] mem [NW];

   always #2.5 clk = ~clk;

   wordmem_cycle_ctrl #(
      .X_BITS(XB), .Y_BITS(YB), .WORD_W(W), .TMO_W(TW), .RESTORE_CYCLES(RC)
   ) i_wordmem_cycle_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .store(store),
      .wdata(wdata), .timeout_lim(timeout_lim), .sense_one(sense_one),
      .sense_zero(sense_zero), .strobe(strobe), .x_sel(x_sel), .y_sel(y_sel),
      .drv_one(drv_one), .drv_zero(drv_zero), .rdata(rdata), .busy(busy),
      .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // One access. late bits answer from strobe cycle late_cyc on, dead bits never.
   task automatic run_cycle(input int a, input bit st, input logic [W-1:0] wd,
                            input logic [W-1:0] late_mask, input int late_cyc,
                            input logic [W-1:0] dead_mask, input int lim_v,
                            input bit poke);
      int lim_eff, last_need, exp_sel, n_sel;
      bit exp_err;
      logic [W-1:0] lost, exp_val, old, seen_drv;
      logic [(1<<XB)-1:0] exp_x;
      logic [(1<<YB)-1:0] exp_y;
      lim_eff   = (lim_v < 1) ? 1 : lim_v;
      last_need = (dead_mask != '0) ? 1000 : ((late_mask != '0) ? late_cyc : 0);
      if (last_need < lim_eff) begin
         exp_sel = last_need + 1; exp_err = 1'b0; lost = '0;
      end else begin
         exp_sel = lim_eff; exp_err = 1'b1;
         lost = dead_mask | ((late_cyc >= lim_eff) ? late_mask : '0);
      end
      old     = mem[a];
      exp_val = st ? wd : (old & ~lost);
      exp_x   = '0; exp_x[a >> YB] = 1'b1;
      exp_y   = '1; exp_y[a % (1 << YB)] = 1'b0;

      timeout_lim = TW'(lim_v);
      start = 1'b1; addr = AW'(a); store = st; wdata = wd;
      step();
      start = 1'b0; addr = '0; wdata = ~wd;
      chk(busy == 1'b1, "R2", "busy after start", 64'(busy), 64'd1);
      chk(err == 1'b0, "R10", "err cleared by new access", 64'(err), 64'd0);
      n_sel = 0;
      while (strobe && n_sel < 40) begin
         chk(x_sel == exp_x, "R3", "x_sel in select", 64'(x_sel), 64'(exp_x));
         chk(y_sel == exp_y, "R3", "y_sel in select", 64'(y_sel), 64'(exp_y));
         for (int b = 0; b < W; b++) begin
            bit r;
            r = !dead_mask[b] && (!late_mask[b] || n_sel >= late_cyc);
            sense_one[b]  = r && old[b];
            sense_zero[b] = r && !old[b];
         end
         if (poke && n_sel == 0) begin
            start = 1'b1; addr = AW'(a ^ 1);
         end
         step();
         start = 1'b0;
         n_sel++;
      end
      sense_one = '1; sense_zero = '0;
      chk(n_sel == exp_sel, exp_err ? "R6" : "R5", "select cycles", 64'(n_sel), 64'(exp_sel));
      seen_drv = drv_one;
      for (int r = 0; r < RC; r++) begin
         chk(strobe == 1'b0 && x_sel == '0 && y_sel == '1, "R3", "lines idle in drive",
             {strobe, 4'(x_sel), 4'(y_sel)}, {1'b0, 4'h0, 4'hf});
         chk(drv_one == exp_val, st ? "R9" : "R8", "drv_one", 64'(drv_one), 64'(exp_val));
         chk(drv_zero == (~exp_val & MASK), "R7", "drv_zero", 64'(drv_zero), 64'(~exp_val & MASK));
         chk(busy == 1'b1 && done == 1'b0, "R7", "busy during drive", {busy, done}, 2'b10);
         if (poke && r == 0) begin
            start = 1'b1; addr = AW'(a ^ 2);
         end
         step();
         start = 1'b0;
      end
      chk(done == 1'b1 && busy == 1'b0, "R10", "done with busy low", {done, busy}, 2'b10);
      chk(err == exp_err, "R6", "err flag", 64'(err), 64'(exp_err));
      chk(rdata == exp_val, "R8", "rdata", 64'(rdata), 64'(exp_val));
      chk(drv_one == '0 && drv_zero == '0, "R7", "bit lines off after drive",
          {drv_one, drv_zero}, 0);
      step();
      chk(done == 1'b0 && busy == 1'b0, "R10", "done single cycle, no restart",
          {done, busy}, 2'b00);
      chk(err == exp_err, "R10", "err held while idle", 64'(err), 64'(exp_err));
      sense_one = '0; sense_zero = '0;
      mem[a] = seen_drv;
   endtask

   initial begin
      for (int i = 0; i < NW; i++) mem[i] = '0;
      repeat (3) step();
      chk(busy == 0 && done == 0 && strobe == 0 && err == 0, "R1", "control outputs at reset",
          {busy, done, strobe, err}, 0);
      chk(x_sel == '0 && y_sel == '1, "R1", "select lines at reset", {4'(x_sel), 4'(y_sel)}, 8'h0f);
      chk(drv_one == '0 && drv_zero == '0 && rdata == '0, "R1", "data at reset",
          {drv_one, drv_zero, rdata}, 0);
      rst_n = 1'b1;
      // sense activity while idle must not reach the register
      sense_one = '1; step(); step(); sense_one = '0;
      chk(rdata == '0 && busy == 1'b0, "R4", "sense ignored while idle", {rdata, busy}, 0);

      // R9: store a distinct word to every address
      for (int a = 0; a < NW; a++)
         run_cycle(a, 1'b1, W'((a * 11 + 3) % 64), '0, 0, '0, 8, a == 5);
      // R8, R4: read back with one late bit at varying position and delay
      for (int a = 0; a < NW; a++)
         run_cycle(a, 1'b0, '0, W'(1 << (a % W)), a % 4, '0, 8, a == 9);
      // R5: last response lands in the final allowed cycle
      run_cycle(3, 1'b0, '0, 6'b000001, 4, '0, 5, 1'b0);
      // R6: one cycle too late, bit is lost and rewritten as 0
      run_cycle(3, 1'b0, '0, 6'b100001, 5, '0, 5, 1'b0);
      run_cycle(3, 1'b0, '0, '0, 0, '0, 5, 1'b0);
      // R6: zero limit behaves as one, dead bits read as 0
      run_cycle(6, 1'b0, '0, '0, 0, 6'b010010, 0, 1'b1);
      // R9, R6: store with a dead bit still writes the full word
      run_cycle(7, 1'b1, 6'b101101, '0, 0, 6'b000100, 3, 1'b0);
      for (int a = 0; a < NW; a++)
         run_cycle(a, 1'b0, '0, '0, 0, '0, 2, 1'b0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule